// File: doc/BRIEF.md
# BLE Advertising Packet CRC and Whitening Encoder

This block turns the header and payload bytes of a Bluetooth Low Energy advertising PDU into the byte stream that a generic packet radio, one that shifts each byte out most significant bit first, must send so that the result on air is a valid BLE packet. It computes the 24-bit BLE CRC over the data, appends it as three bytes, whitens every byte with an LFSR seeded from the channel number, and bit-reverses each byte on the way out. Preamble, access address and the radio itself belong to other blocks.

A packet begins with a one-cycle start strobe that carries the data length and the channel number. The block then takes data bytes through a valid/ready input and returns encoded bytes through a valid/ready output, one byte at a time. Each byte takes eight clock cycles, one per bit, for the CRC and whitening. After the last CRC byte leaves, a done flag pulses for one cycle. A start that arrives while a packet is in progress is ignored.

Top module: `ble_pdu_encoder`

## Requirements
- R1: The CRC register resets to 0x555555 at each start. It consumes data bits least significant bit first. Per bit it shifts left by one, and when the bit shifted out of bit 23 differs from the data bit it XORs the register with 0x00065B.
- R2: The whitening LFSR is loaded with the 8-bit reverse of the zero-extended channel number, OR-ed with 0x02. Per bit, taken from bit 0 up to bit 7, if LFSR bit 7 is set the data bit is inverted and the LFSR is XORed with 0x11; then the LFSR shifts left by one with a zero entering bit 0.
- R3: Each output byte equals the 8-bit reverse of the whitened byte. Whitening runs continuously over data and CRC bytes in stream order.
- R4: After the data, three CRC bytes follow, built from CRC bits 23:16, then 15:8, then 7:0. Each is bit-reversed before whitening, and the CRC no longer changes while these bytes are produced.
- R5: The number of data bytes accepted is min(len_i, 29), so a packet never exceeds 32 bytes including the CRC.
- R6: Data bytes are taken only when in_valid_i and in_ready_o are both high. An output byte is held stable with out_valid_o high until out_ready_i accepts it. in_ready_o and out_valid_o are never high together.
- R7: done_o is high for exactly one cycle, the cycle after the last CRC byte is accepted, and busy_o is low in that cycle.
- R8: A start strobe while busy_o is high does not change the length, channel or content of the packet in progress.
- R9: With len_i equal to 0, the packet consists of the three CRC bytes only, computed from the initial CRC value.
- R10: An advertising packet with header 0x42 and length field 0x1B, followed by 27 body bytes (29 data bytes in all), encodes to 32 correct bytes on every advertising channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start of a packet, sampled when idle |
| len_i | input | 6 | Number of data bytes (header and payload) |
| chan_i | input | 6 | BLE channel number for the whitening seed |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input data byte |
| in_ready_o | output | 1 | Encoder can take a data byte |
| out_valid_o | output | 1 | Encoded byte valid |
| out_data_o | output | 8 | Encoded byte, ready for MSB-first transmission |
| out_ready_i | input | 1 | Consumer accepts the encoded byte |
| busy_o | output | 1 | A packet is in progress |
| done_o | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench builds the block with its default parameters: a 32-byte packet limit, 6-bit length and channel inputs, and the standard CRC seed, polynomial and whitening taps. With these values a sweep over every data length from 0 to 31 covers the empty packet, every ordinary size and the clamp above 29. A second sweep over all 40 channel numbers with the full 29-byte advertising PDU covers every whitening seed the block can meet. Periodic output stalls and a start strobe injected mid-packet exercise the hold and ignore rules.

// File: rtl/ble_enc_pkg.sv
package ble_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2,
    ST_EMIT  = 2'd3
  } enc_state_e;

  // Mirror the bit order of one byte.
  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // One CRC bit step: shift left, fold in the polynomial on mismatch.
  function automatic logic [23:0] crc_step(input logic [23:0] c,
                                           input logic        d,
                                           input logic [23:0] poly);
    logic [23:0] n;
    n = {c[22:0], 1'b0};
    if (c[23] != d) n = n ^ poly;
    return n;
  endfunction

  // One whitening LFSR step: conditional tap XOR, then shift left.
  function automatic logic [7:0] lfsr_step(input logic [7:0] s,
                                           input logic [7:0] tap);
    logic [7:0] t;
    t = s[7] ? (s ^ tap) : s;
    return {t[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/ble_crc24.sv
module ble_crc24 #(
  parameter logic [23:0] INIT = 24'h555555,
  parameter logic [23:0] POLY = 24'h00065B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        step_i,
  input  logic        bit_i,
  output logic [23:0] crc_o
);
  import ble_enc_pkg::*;

  logic [23:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (init_i) crc_q <= INIT;
    else if (step_i) crc_q <= crc_step(crc_q, bit_i, POLY);
  end

  assign crc_o = crc_q;

  // R1: every start reloads the seed
  assert_crc_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> crc_o == INIT);

  // R4: with no step the register holds (CRC bytes are being emitted)
  assert_crc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i) |=> $stable(crc_o));

endmodule

// File: rtl/ble_whiten_lfsr.sv
module ble_whiten_lfsr #(
  parameter logic [7:0] TAP = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] seed_i,
  input  logic       step_i,
  input  logic       bit_i,
  output logic       bit_o
);
  import ble_enc_pkg::*;

  logic [7:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lfsr_q <= '0;
    else if (load_i) lfsr_q <= seed_i;
    else if (step_i) lfsr_q <= lfsr_step(lfsr_q, TAP);
  end

  assign bit_o = bit_i ^ lfsr_q[7];

  // R2: a shift always brings a zero into bit 0
  assert_lfsr_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> lfsr_q[0] == 1'b0);

  // R2: the seed always carries bit 1 set
  assert_lfsr_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> lfsr_q[1] == 1'b1);

endmodule

// File: rtl/ble_pdu_encoder.sv
module ble_pdu_encoder #(
  parameter int          MAX_BYTES  = 32,
  parameter int          LEN_W      = 6,
  parameter int          CHAN_W     = 6,
  parameter logic [23:0] CRC_INIT   = 24'h555555,
  parameter logic [23:0] CRC_POLY   = 24'h00065B,
  parameter logic [7:0]  WHITEN_TAP = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  import ble_enc_pkg::*;

  localparam int CRC_BYTES = 3;
  localparam int MAX_DATA  = MAX_BYTES - CRC_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  enc_state_e       state_q;
  logic [CNT_W-1:0] n_data_q;
  logic [CNT_W-1:0] byte_cnt_q;
  logic [2:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic [7:0]       wb_q;
  logic             is_crc_q;
  logic             done_q;

  // Named internal events
  logic             start_take;
  logic             fetch_data;
  logic             fetch_crc;
  logic             in_take;
  logic             out_take;
  logic             last_byte;
  logic             crc_step_en;
  logic             wh_step_en;
  logic             wh_bit;
  logic [23:0]      crc_val;
  logic [7:0]       crc_byte;
  logic [7:0]       seed;
  logic [CNT_W-1:0] len_clamped;
  logic [CNT_W-1:0] crc_idx;

  always_comb begin
    if (32'(len_i) > 32'(MAX_DATA)) len_clamped = CNT_W'(MAX_DATA);
    else                            len_clamped = CNT_W'(len_i);
  end

  assign seed        = rev8(8'({chan_i})) | 8'h02;
  assign start_take  = (state_q == ST_IDLE) && start_i;
  assign fetch_data  = (state_q == ST_FETCH) && (byte_cnt_q < n_data_q);
  assign fetch_crc   = (state_q == ST_FETCH) && !(byte_cnt_q < n_data_q);
  assign in_take     = fetch_data && in_valid_i;
  assign out_take    = (state_q == ST_EMIT) && out_ready_i;
  assign last_byte   = (byte_cnt_q == n_data_q + CNT_W'(CRC_BYTES - 1));
  assign crc_step_en = (state_q == ST_SHIFT) && !is_crc_q;
  assign wh_step_en  = (state_q == ST_SHIFT);
  assign crc_idx     = byte_cnt_q - n_data_q;

  always_comb begin
    case (crc_idx)
      CNT_W'(0): crc_byte = crc_val[23:16];
      CNT_W'(1): crc_byte = crc_val[15:8];
      default:   crc_byte = crc_val[7:0];
    endcase
  end

  ble_crc24 #(
    .INIT (CRC_INIT),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (start_take),
    .step_i (crc_step_en),
    .bit_i  (sh_q[0]),
    .crc_o  (crc_val)
  );

  ble_whiten_lfsr #(
    .TAP (WHITEN_TAP)
  ) u_whiten (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_take),
    .seed_i (seed),
    .step_i (wh_step_en),
    .bit_i  (sh_q[0]),
    .bit_o  (wh_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      n_data_q   <= '0;
      byte_cnt_q <= '0;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      wb_q       <= '0;
      is_crc_q   <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            n_data_q   <= len_clamped;
            byte_cnt_q <= '0;
            state_q    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (in_take) begin
            sh_q      <= in_data_i;
            is_crc_q  <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_SHIFT;
          end else if (fetch_crc) begin
            sh_q      <= rev8(crc_byte);
            is_crc_q  <= 1'b1;
            bit_cnt_q <= '0;
            state_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          sh_q      <= {1'b0, sh_q[7:1]};
          wb_q      <= {wh_bit, wb_q[7:1]};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (out_ready_i) begin
            byte_cnt_q <= byte_cnt_q + CNT_W'(1);
            if (last_byte) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = fetch_data;
  assign out_valid_o = (state_q == ST_EMIT);
  assign out_data_o  = rev8(wb_q);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  // R6: a stalled output byte is held
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  // R6: input and output handshakes never overlap
  assert_hs_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready_o && out_valid_o));

  // R7: done follows acceptance of the final byte and finds the block idle
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(out_take && last_byte)));

  // R5: the packet size stays within the clamp
  assert_len_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (32'(n_data_q) <= 32'(MAX_DATA) &&
                32'(byte_cnt_q) < 32'(n_data_q) + CRC_BYTES));

  // R8: a start while busy leaves the packet length untouched
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !(out_take && last_byte)) |=> (busy_o && $stable(n_data_q)));

endmodule

// File: tb/ble_pdu_encoder_tb.sv
module ble_pdu_encoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [5:0] len_i = '0;
  logic [5:0] chan_i = '0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b0;
  logic       busy_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] pkt [0:63];
  logic [7:0] exp_b [0:31];
  int         exp_n;

  always #10 clk = ~clk;  // 50 MHz

  ble_pdu_encoder u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .len_i       (len_i),
    .chan_i      (chan_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] mirror(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (v[i]) r = r | (8'h80 >> i);
    return r;
  endfunction

  // Reference model built from the requirements (R1-style CRC, R2 whitening).
  task automatic build_expect(input int len, input int ch);
    int          nd;
    logic [23:0] c;
    logic [7:0]  raw [0:31];
    logic [7:0]  lf;
    nd = (len > 29) ? 29 : len;
    c = 24'h555555;
    for (int i = 0; i < nd; i++) begin
      raw[i] = pkt[i];
      for (int b = 0; b < 8; b++) begin
        logic top;
        top = c[23];
        c = c << 1;
        if (top ^ pkt[i][b]) c = c ^ 24'h00065B;
      end
    end
    raw[nd]   = mirror(c[23:16]);
    raw[nd+1] = mirror(c[15:8]);
    raw[nd+2] = mirror(c[7:0]);
    exp_n = nd + 3;
    lf = mirror(8'(ch)) | 8'h02;
    for (int i = 0; i < exp_n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (lf[7]) begin
          lf = lf ^ 8'h11;
          raw[i][b] = ~raw[i][b];
        end
        lf = lf << 1;
      end
      exp_b[i] = mirror(raw[i]);
    end
  endtask

  task automatic run_pkt(input int len, input int ch, input bit stall,
                         input bit poke, input string req);
    int   idx_in = 0;
    int   idx_out = 0;
    int   cyc = 0;
    bit   held = 1'b0;
    logic [7:0] held_v = '0;
    build_expect(len, ch);
    @(negedge clk);
    start_i = 1'b1; len_i = 6'(len); chan_i = 6'(ch);
    @(negedge clk);
    start_i = 1'b0;
    chan_i = 6'(ch + 5);  // later changes must not matter
    while (idx_out < exp_n && cyc < 4000) begin
      bit ti, to;
      if (held) begin
        check(out_valid_o && out_data_o == held_v, "R6 hold", int'(out_data_o), int'(held_v));
        held = 1'b0;
      end
      in_valid_i  = in_ready_o;
      in_data_i   = pkt[idx_in];
      out_ready_i = out_valid_o && !(stall && (cyc % 3 == 0));
      start_i     = poke && (cyc == 5);
      len_i       = poke ? 6'd3 : 6'(len);
      ti = in_ready_o && in_valid_i;
      to = out_valid_o && out_ready_i;
      if (out_valid_o && !out_ready_i) begin
        held = 1'b1; held_v = out_data_o;
      end
      if (to) check(out_data_o == exp_b[idx_out], req, int'(out_data_o), int'(exp_b[idx_out]));
      if (in_ready_o) check(idx_in < ((len > 29) ? 29 : len), "R5 in_ready count", idx_in, len);
      @(posedge clk);
      if (ti) idx_in++;
      if (to) idx_out++;
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    in_valid_i = 1'b0; out_ready_i = 1'b0;
    check(idx_out == exp_n, "R5 byte count", idx_out, exp_n);
    check(done_o == 1'b1 && busy_o == 1'b0, "R7 done pulse", {30'b0, done_o, busy_o}, 2);
    @(negedge clk);
    check(done_o == 1'b0 && out_valid_o == 1'b0, "R7 done one cycle", {30'b0, done_o, out_valid_o}, 0);
  endtask

  task automatic load_adv();
    logic [7:0] hdr [0:12];
    hdr = '{8'h42, 8'h1B, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6,
            8'h02, 8'h01, 8'h05, 8'h11, 8'h08};
    for (int i = 0; i < 13; i++) pkt[i] = hdr[i];
    for (int i = 13; i < 29; i++) pkt[i] = 8'(8'h41 + i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) pkt[i] = 8'((i * 37 + 11) ^ (i << 3));
    repeat (3) @(negedge clk);
    check(busy_o == 0 && out_valid_o == 0 && in_ready_o == 0 && done_o == 0,
          "R6 reset state", {28'b0, busy_o, out_valid_o, in_ready_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && out_valid_o == 0, "R7 idle after reset", {30'b0, busy_o, out_valid_o}, 0);

    // R9: empty packet, CRC bytes only
    run_pkt(0, 37, 1'b0, 1'b0, "R9 empty packet");
    // R1 R3 R4 R5: sweep every length including clamp at 30 and 31
    for (int l = 1; l < 32; l++) run_pkt(l, (l * 7) % 40, l[0], 1'b0, "R1 R3 R4 length sweep");
    // R8: start pulse mid-packet ignored
    run_pkt(12, 20, 1'b0, 1'b1, "R8 start while busy");
    run_pkt(40, 3, 1'b1, 1'b1, "R8 R5 clamp with poke");
    // R10 R2: advertising PDU on every channel
    load_adv();
    for (int ch = 0; ch < 40; ch++) run_pkt(29, ch, ch[1], 1'b0, "R10 R2 channel sweep");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule